// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port RAM

This block is one storage array that two ports reach at different data widths. The narrow port moves a few bits per access. The wide port moves a whole group of narrow words in one access. Each port derives its own address width from the total capacity and its own data width, so both ports cover exactly the same bits.

Narrow address k refers to the k-th narrow slot of the flat bit vector. Wide address j refers to the j-th run of wide-width bits, starting at bit 0. Both ports share one clock. Each port has a clock enable, a write enable, an address, write data and registered read data. Reads are read-first, and the width conversion is written as plain behavioural logic around a single wide-word array.

Top module: `asym_dpram`

## Requirements
- R1: While rst_ni is low, both read data outputs are zero.
- R2: In the default configuration (64 bits, 1-bit narrow port, 32-bit wide port), an enabled narrow read of address k returns bit k of the 64-bit contents. Those contents may have been written through the wide port.
- R3: Wide address 0 holds contents bits 31:0 and wide address 1 holds bits 63:32, with contents bit 32*j+i on wide data bit i. Narrow writes show up in wide reads at these positions.
- R4: Read data appears on the output one clock edge after the edge that samples an enabled read, and not before that edge.
- R5: A read and a write to the same address on the same port in the same cycle returns the data held before the write. The new data is returned by the next read.
- R6: When a port's enable is low, its write enable has no effect on the contents and its read data output holds its value.
- R7: A narrow write changes only the addressed narrow slot. Every other bit of the contents keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the read registers |
| n_en_i | input | 1 | Narrow port enable |
| n_we_i | input | 1 | Narrow port write enable |
| n_addr_i | input | 6 | Narrow port address |
| n_wdata_i | input | 1 | Narrow port write data |
| n_rdata_o | output | 1 | Narrow port read data |
| w_en_i | input | 1 | Wide port enable |
| w_we_i | input | 1 | Wide port write enable |
| w_addr_i | input | 1 | Wide port address |
| w_wdata_i | input | 32 | Wide port write data |
| w_rdata_o | output | 32 | Wide port read data |

## Verification
The hardest case to reach is a same-port read-modify collision, where the old value must come out while the new value is stored. The stimulus makes the written value the complement of the stored one, so the old value and the new value can be told apart. A follow-up read then shows the new value.

Cross-port visibility is covered in both directions. Wide words are written with an asymmetric pattern and then probed bit by bit through the narrow port. Narrow writes are then gathered back through wide reads. Disabled writes are placed directly between known reads.

// File: rtl/adp_pkg.sv
package adp_pkg;
  function automatic int clog2_min1(input int v);
    int r;
    r = $clog2(v);
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/adp_map.sv
// Splits a narrow address into wide row and lane inside that row.
module adp_map #(
  parameter int NA_AW  = 6,
  parameter int ROW_W  = 1,
  parameter int LANE_W = 5
) (
  input  logic [NA_AW-1:0]  n_addr_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam int NA_PAD = ROW_W + LANE_W;
  logic [NA_PAD-1:0] addr_ext;

  always_comb begin
    addr_ext = '0;
    addr_ext[NA_AW-1:0] = n_addr_i;
    lane_o = addr_ext[LANE_W-1:0];
    row_o  = addr_ext[NA_PAD-1:LANE_W];
  end
endmodule

// File: rtl/adp_store.sv
// Wide-word array. The narrow port writes one lane and the wide port writes a full row.
module adp_store #(
  parameter int NARROW_W = 1,
  parameter int WIDE_W   = 32,
  parameter int DEPTH    = 2,
  parameter int ROW_W    = 1,
  parameter int LANE_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                n_wr_i,
  input  logic                n_rd_i,
  input  logic [ROW_W-1:0]    n_row_i,
  input  logic [LANE_W-1:0]   n_lane_i,
  input  logic [NARROW_W-1:0] n_wdata_i,
  output logic [NARROW_W-1:0] n_rdata_o,
  input  logic                w_wr_i,
  input  logic                w_rd_i,
  input  logic [ROW_W-1:0]    w_row_i,
  input  logic [WIDE_W-1:0]   w_wdata_i,
  output logic [WIDE_W-1:0]   w_rdata_o
);
  logic [WIDE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (w_wr_i) mem_q[w_row_i] <= w_wdata_i;
    if (n_wr_i) mem_q[n_row_i][n_lane_i*NARROW_W +: NARROW_W] <= n_wdata_i;
  end

  // read-first: nonblocking update leaves old data visible this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_rdata_o <= '0;
      w_rdata_o <= '0;
    end else begin
      if (n_rd_i) n_rdata_o <= mem_q[n_row_i][n_lane_i*NARROW_W +: NARROW_W];
      if (w_rd_i) w_rdata_o <= mem_q[w_row_i];
    end
  end
endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import adp_pkg::*;
#(
  parameter int MEM_BITS = 64,
  parameter int NARROW_W = 1,
  parameter int WIDE_W   = 32,
  localparam int RATIO   = WIDE_W / NARROW_W,
  localparam int DEPTH   = MEM_BITS / WIDE_W,
  localparam int NA_AW   = clog2_min1(MEM_BITS / NARROW_W),
  localparam int WA_AW   = clog2_min1(DEPTH),
  localparam int LANE_W  = clog2_min1(RATIO)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                n_en_i,
  input  logic                n_we_i,
  input  logic [NA_AW-1:0]    n_addr_i,
  input  logic [NARROW_W-1:0] n_wdata_i,
  output logic [NARROW_W-1:0] n_rdata_o,
  input  logic                w_en_i,
  input  logic                w_we_i,
  input  logic [WA_AW-1:0]    w_addr_i,
  input  logic [WIDE_W-1:0]   w_wdata_i,
  output logic [WIDE_W-1:0]   w_rdata_o
);
  logic [WA_AW-1:0]  n_row;
  logic [LANE_W-1:0] n_lane;

  adp_map #(.NA_AW(NA_AW), .ROW_W(WA_AW), .LANE_W(LANE_W)) u_map (
    .n_addr_i(n_addr_i),
    .row_o   (n_row),
    .lane_o  (n_lane)
  );

  adp_store #(
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .DEPTH(DEPTH),
    .ROW_W(WA_AW), .LANE_W(LANE_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .n_wr_i   (n_en_i & n_we_i),
    .n_rd_i   (n_en_i),
    .n_row_i  (n_row),
    .n_lane_i (n_lane),
    .n_wdata_i(n_wdata_i),
    .n_rdata_o(n_rdata_o),
    .w_wr_i   (w_en_i & w_we_i),
    .w_rd_i   (w_en_i),
    .w_row_i  (w_addr_i),
    .w_wdata_i(w_wdata_i),
    .w_rdata_o(w_rdata_o)
  );
endmodule

// File: rtl/asym_dpram_chk.sv
// Shadow model of the flat contents, built from port traffic only.
module asym_dpram_chk #(
  parameter int MEM_BITS = 64,
  parameter int NARROW_W = 1,
  parameter int WIDE_W   = 32,
  parameter int NA_AW    = 6,
  parameter int WA_AW    = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                n_en_i,
  input logic                n_we_i,
  input logic [NA_AW-1:0]    n_addr_i,
  input logic [NARROW_W-1:0] n_wdata_i,
  input logic [NARROW_W-1:0] n_rdata_o,
  input logic                w_en_i,
  input logic                w_we_i,
  input logic [WA_AW-1:0]    w_addr_i,
  input logic [WIDE_W-1:0]   w_wdata_i,
  input logic [WIDE_W-1:0]   w_rdata_o
);
  logic [MEM_BITS-1:0] shadow_q, known_q;
  logic [NARROW_W-1:0] n_exp;
  logic [WIDE_W-1:0]   w_exp;
  logic                n_known, w_known;

  always_comb begin
    n_exp   = shadow_q[int'(n_addr_i)*NARROW_W +: NARROW_W];
    n_known = &known_q[int'(n_addr_i)*NARROW_W +: NARROW_W];
    w_exp   = shadow_q[int'(w_addr_i)*WIDE_W +: WIDE_W];
    w_known = &known_q[int'(w_addr_i)*WIDE_W +: WIDE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      known_q  <= '0;
    end else begin
      if (w_en_i && w_we_i) begin
        shadow_q[int'(w_addr_i)*WIDE_W +: WIDE_W] <= w_wdata_i;
        known_q[int'(w_addr_i)*WIDE_W +: WIDE_W]  <= '1;
      end
      if (n_en_i && n_we_i) begin
        shadow_q[int'(n_addr_i)*NARROW_W +: NARROW_W] <= n_wdata_i;
        known_q[int'(n_addr_i)*NARROW_W +: NARROW_W]  <= '1;
      end
    end
  end

  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (n_rdata_o == '0 && w_rdata_o == '0);
    end
  end

  // R2
  narrow_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_en_i && n_known) |=> n_rdata_o == $past(n_exp));

  // R3
  wide_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_en_i && w_known) |=> w_rdata_o == $past(w_exp));

  // R6
  narrow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n_en_i |=> $stable(n_rdata_o));

  // R6
  wide_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_en_i |=> $stable(w_rdata_o));
endmodule

bind asym_dpram asym_dpram_chk #(
  .MEM_BITS(MEM_BITS), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
  .NA_AW(NA_AW), .WA_AW(WA_AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .n_en_i(n_en_i), .n_we_i(n_we_i), .n_addr_i(n_addr_i),
  .n_wdata_i(n_wdata_i), .n_rdata_o(n_rdata_o),
  .w_en_i(w_en_i), .w_we_i(w_we_i), .w_addr_i(w_addr_i),
  .w_wdata_i(w_wdata_i), .w_rdata_o(w_rdata_o)
);

// File: tb/asym_dpram_bench.sv
module asym_dpram_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       we;
    logic [5:0] addr;
    logic       d;
  } n_vec_t;

  // narrow accesses: writes update the model, reads compare against it
  localparam int NV = 12;
  localparam n_vec_t N_TAB [NV] = '{
    '{1'b0, 6'd0,  1'b0}, '{1'b0, 6'd1,  1'b0}, '{1'b0, 6'd31, 1'b0},
    '{1'b0, 6'd32, 1'b0}, '{1'b0, 6'd47, 1'b0}, '{1'b0, 6'd63, 1'b0},
    '{1'b1, 6'd0,  1'b1}, '{1'b1, 6'd33, 1'b1}, '{1'b1, 6'd63, 1'b0},
    '{1'b0, 6'd0,  1'b0}, '{1'b0, 6'd33, 1'b0}, '{1'b0, 6'd63, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        n_en_i = 1'b0, n_we_i = 1'b0, n_wdata_i = 1'b0;
  logic [5:0]  n_addr_i = '0;
  logic        n_rdata_o;
  logic        w_en_i = 1'b0, w_we_i = 1'b0;
  logic [0:0]  w_addr_i = '0;
  logic [31:0] w_wdata_i = '0;
  logic [31:0] w_rdata_o;

  int total = 0, bad = 0;
  logic [63:0] model;
  bit done = 0;

  asym_dpram u_asym_dpram (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic n_access(input logic we, input logic [5:0] a, input logic d);
    @(negedge clk_i);
    n_en_i = 1'b1; n_we_i = we; n_addr_i = a; n_wdata_i = d;
    @(negedge clk_i);
    n_en_i = 1'b0; n_we_i = 1'b0;
  endtask

  task automatic w_access(input logic we, input logic a, input logic [31:0] d);
    @(negedge clk_i);
    w_en_i = 1'b1; w_we_i = we; w_addr_i = a; w_wdata_i = d;
    @(negedge clk_i);
    w_en_i = 1'b0; w_we_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 narrow reset", {31'd0, n_rdata_o}, 32'd0);
    check("R1 wide reset", w_rdata_o, 32'd0);
    rst_ni = 1'b1;

    model = 64'h1234_FEDC_A5C3_0F96;
    w_access(1'b1, 1'b0, model[31:0]);
    w_access(1'b1, 1'b1, model[63:32]);

    // R2 and R7: table walk over narrow reads and writes
    for (int i = 0; i < NV; i++) begin
      n_access(N_TAB[i].we, N_TAB[i].addr, N_TAB[i].d);
      if (N_TAB[i].we) model[N_TAB[i].addr] = N_TAB[i].d;
      else check("R2 narrow read", {31'd0, n_rdata_o}, {31'd0, model[N_TAB[i].addr]});
    end

    // R3, R7: wide reads gather narrow writes, others unchanged
    w_access(1'b0, 1'b0, '0);
    check("R3 wide word0", w_rdata_o, model[31:0]);
    w_access(1'b0, 1'b1, '0);
    check("R3 wide word1", w_rdata_o, model[63:32]);

    // R5 narrow read-first
    n_access(1'b1, 6'd5, ~model[5]);
    check("R5 narrow old data", {31'd0, n_rdata_o}, {31'd0, model[5]});
    model[5] = ~model[5];
    n_access(1'b0, 6'd5, 1'b0);
    check("R5 narrow new data", {31'd0, n_rdata_o}, {31'd0, model[5]});

    // R5 wide read-first
    w_access(1'b1, 1'b1, ~model[63:32]);
    check("R5 wide old data", w_rdata_o, model[63:32]);
    model[63:32] = ~model[63:32];
    w_access(1'b0, 1'b1, '0);
    check("R5 wide new data", w_rdata_o, model[63:32]);

    // R6: write enable with enable low
    @(negedge clk_i);
    n_en_i = 1'b0; n_we_i = 1'b1; n_addr_i = 6'd5; n_wdata_i = ~model[5];
    w_en_i = 1'b0; w_we_i = 1'b1; w_addr_i = 1'b0; w_wdata_i = ~model[31:0];
    @(negedge clk_i);
    n_we_i = 1'b0; w_we_i = 1'b0;
    check("R6 wide output held", w_rdata_o, model[63:32]);
    check("R6 narrow output held", {31'd0, n_rdata_o}, {31'd0, model[5]});
    w_access(1'b0, 1'b0, '0);
    check("R6 wide contents unchanged", w_rdata_o, model[31:0]);
    n_access(1'b0, 6'd5, 1'b0);
    check("R6 narrow contents unchanged", {31'd0, n_rdata_o}, {31'd0, model[5]});

    // R4: output changes only at the edge after the read is sampled
    n_access(1'b0, 6'd2, 1'b0);
    @(negedge clk_i);
    n_en_i = 1'b1; n_addr_i = 6'd3;
    #1;
    check("R4 not before edge", {31'd0, n_rdata_o}, {31'd0, model[2]});
    @(negedge clk_i);
    n_en_i = 1'b0;
    check("R4 after one edge", {31'd0, n_rdata_o}, {31'd0, model[3]});

    // R2: both ports active together on different words
    @(negedge clk_i);
    n_en_i = 1'b1; n_addr_i = 6'd40;
    w_en_i = 1'b1; w_we_i = 1'b1; w_addr_i = 1'b0; w_wdata_i = 32'h0000_0001;
    @(negedge clk_i);
    n_en_i = 1'b0; w_en_i = 1'b0; w_we_i = 1'b0;
    check("R2 concurrent narrow read", {31'd0, n_rdata_o}, {31'd0, model[40]});
    model[31:0] = 32'h0000_0001;
    n_access(1'b0, 6'd0, 1'b0);
    check("R2 narrow sees wide write", {31'd0, n_rdata_o}, 32'd1);

    // R1: reset again clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 reset reapplied narrow", {31'd0, n_rdata_o}, 32'd0);
    check("R1 reset reapplied wide", w_rdata_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    finish_run();
  end
endmodule